// File: doc/BRIEF.md
# Prescaled Square-Wave Tone and Noise Source

This block turns a fast system clock into three independent square-wave tone bits and one pseudo-random noise bit, for use as the raw sources of a small sound synthesiser. The clock is first divided by sixteen by one prescaler that all generators share. Each prescaler pulse then advances four programmable period counters: one for each of the three tone channels and one for noise.

Each tone channel takes its 12-bit half-period from a pair of 8-bit registers. The fine register supplies the low byte. The low nibble of the coarse register supplies the top four bits. A tone bit flips every time its counter runs out. The noise counter uses a 5-bit period. Each time it runs out, a 17-bit linear feedback shift register steps once, and the bit leaving the register is the noise output.

The register values come in as plain level inputs and can change at any time. Mixing, volume and the host bus are handled elsewhere.

Top module: `sq_noise_gen`

## Requirements
- R1: While `rst_n` is low, every `tone_out` bit is 0, `noise_out` is 1 (the shift register is seeded with the value 1), and the prescaler and all period counters are cleared.
- R2: The outputs change only on every 16th rising clock edge after reset release. With all periods equal to 1, the outputs hold their reset values after 15 edges and first change on the 16th edge.
- R3: The half-period of channel i is `{coarse_reg[i][3:0], fine_reg[i]}`: fine supplies bits 7..0 and the coarse low nibble supplies bits 11..8. Index 0, 1 and 2 are channels A, B and C.
- R4: Bits 7..4 of every coarse register have no effect on any output.
- R5: A tone bit inverts once every P prescaler pulses, that is every 16·P clocks, where P is its half-period. A full wave cycle therefore lasts 32·P clocks.
- R6: A programmed period of 0, for a tone channel or for noise, gives exactly the same output as a period of 1.
- R7: The noise period N is `noise_reg[4:0]`, and bits 7..5 of `noise_reg` have no effect.
- R8: The noise shift register steps once every N prescaler pulses. On each step the new bit 16 is the old bit 0 XOR the old bit 3, and the other bits shift right by one, which gives the polynomial x^17+x^14+1. `noise_out` is bit 0.
- R9: If a period is lowered to a value at or below the count already reached, the counter expires on the next prescaler pulse.
- R10: The three channels count independently. A register write to one channel does not change the timing of the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_reg | input | NCH x 8 | Coarse period register per channel; low nibble used |
| fine_reg | input | NCH x 8 | Fine period register per channel |
| noise_reg | input | 8 | Noise period register; low five bits used |
| tone_out | output | NCH | Square-wave bit per channel |
| noise_out | output | 1 | Pseudo-random noise bit |

## Verification
The bench runs four register settings. The first sets periods of 0 and 1 on different channels, which separates correct zero handling from a counter that wraps through its full range. The second sets the upper coarse and noise bits to 1 and uses unequal mid-range periods, including one that needs only coarse bits, which shows whether the fields are assembled in the right order and whether the unused bits are masked. The third lowers a period while its counter is part way through, which tests the expire-at-or-above rule. The last uses the largest tone and noise periods, which exposes any counter or carry that is too narrow. In every run the outputs are compared each clock against a behavioural model of the prescaler, the counters and the shift register.

// File: rtl/sqn_pkg.sv
package sqn_pkg;
  localparam int REG_W    = 8;
  localparam int PRE_DIV  = 16;
  localparam int TONE_W   = 12;
  localparam int NOISE_W  = 5;
  localparam int LFSR_W   = 17;
  localparam int LFSR_TAP = 14;

  // Assemble a tone half-period from the coarse nibble and the fine byte.
  function automatic logic [TONE_W-1:0] tone_period(
    input logic [TONE_W-REG_W-1:0] coarse_lo,
    input logic [REG_W-1:0]        fine
  );
    return {coarse_lo, fine};
  endfunction

  // Step a Fibonacci LFSR that shifts toward bit 0; feedback enters the top bit.
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[0] ^ s[LFSR_W-LFSR_TAP];
    return {fb, s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/sqn_prescaler.sv
module sqn_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sqn_period_counter.sv
module sqn_period_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] period,
  output logic         expire,
  output logic         wave
);
  logic [W-1:0] cnt;
  logic [W:0]   next_cnt;
  logic [W:0]   eff;
  logic         reached;

  // A zero period counts as one.
  assign eff      = (period == '0) ? (W+1)'(1) : {1'b0, period};
  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign reached  = (next_cnt >= eff);
  assign expire   = adv & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (expire) begin
      cnt  <= '0;
      wave <= ~wave;
    end else if (adv) begin
      cnt  <= next_cnt[W-1:0];
    end
  end
endmodule

// File: rtl/sqn_noise_lfsr.sv
module sqn_noise_lfsr #(
  parameter int W    = 17,
  parameter int SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state,
  output logic         bit_out
);
  import sqn_pkg::*;

  assign bit_out = state[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= W'(SEED);
    else if (step) state <= lfsr_next(state);
  end
endmodule

// File: rtl/sq_noise_gen.sv
module sq_noise_gen #(
  parameter int NCH = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NCH-1:0][sqn_pkg::REG_W-1:0]      coarse_reg,
  input  logic [NCH-1:0][sqn_pkg::REG_W-1:0]      fine_reg,
  input  logic [sqn_pkg::REG_W-1:0]               noise_reg,
  output logic [NCH-1:0]                          tone_out,
  output logic                                    noise_out
);
  import sqn_pkg::*;

  localparam int CLO_W = TONE_W - REG_W;

  // Internal events, named for the checker.
  logic                  pre_tick;
  logic [NCH-1:0]        tone_expire;
  logic                  noise_step;
  logic                  noise_wave;
  logic [LFSR_W-1:0]     lfsr_state;
  logic [NOISE_W-1:0]    noise_period;

  sqn_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pre_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_tone
    logic [TONE_W-1:0] period;
    assign period = tone_period(coarse_reg[g][CLO_W-1:0], fine_reg[g]);

    sqn_period_counter #(.W(TONE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (pre_tick),
      .period (period),
      .expire (tone_expire[g]),
      .wave   (tone_out[g])
    );
  end

  assign noise_period = noise_reg[NOISE_W-1:0];

  sqn_period_counter #(.W(NOISE_W)) u_noise_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (pre_tick),
    .period (noise_period),
    .expire (noise_step),
    .wave   (noise_wave)
  );

  sqn_noise_lfsr #(.W(LFSR_W), .SEED(1)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (noise_step),
    .state   (lfsr_state),
    .bit_out (noise_out)
  );
endmodule

// File: rtl/sq_noise_gen_chk.sv
module sq_noise_gen_chk #(
  parameter int NCH    = 3,
  parameter int DIV    = 16,
  parameter int LFSR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pre_tick,
  input logic [NCH-1:0]    tone_expire,
  input logic [NCH-1:0]    tone_out,
  input logic              noise_step,
  input logic              noise_wave,
  input logic              noise_out,
  input logic [LFSR_W-1:0] lfsr_state
);
  // Clocks since the last prescaler pulse, kept here to check the spacing.
  int gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap <= 0;
    else if (pre_tick) gap <= 0;
    else               gap <= gap + 1;
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> (gap == DIV - 1));

  p_expire_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|tone_expire) |-> pre_tick);

  p_tone_flips_on_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tone_out ^ $past(tone_out)) == $past(tone_expire)));

  p_noise_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !noise_step |=> $stable(noise_out));

  p_noise_step_paced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    noise_step |=> (noise_wave != $past(noise_wave)));

  p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);
endmodule

bind sq_noise_gen sq_noise_gen_chk #(.NCH(NCH), .DIV(sqn_pkg::PRE_DIV), .LFSR_W(sqn_pkg::LFSR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pre_tick    (pre_tick),
  .tone_expire (tone_expire),
  .tone_out    (tone_out),
  .noise_step  (noise_step),
  .noise_wave  (noise_wave),
  .noise_out   (noise_out),
  .lfsr_state  (lfsr_state)
);

// File: tb/sq_noise_gen_tb.sv
module sq_noise_gen_tb;
  localparam int NCH = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NCH-1:0][7:0]   coarse_reg = '0;
  logic [NCH-1:0][7:0]   fine_reg = '0;
  logic [7:0]            noise_reg = '0;
  logic [NCH-1:0]        tone_out;
  logic                  noise_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R5";
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  sq_noise_gen #(.NCH(NCH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .coarse_reg (coarse_reg),
    .fine_reg   (fine_reg),
    .noise_reg  (noise_reg),
    .tone_out   (tone_out),
    .noise_out  (noise_out)
  );

  // Behavioural reference: integers only, stepped at each rising edge.
  int m_phase;
  int m_cnt [NCH];
  int m_wave [NCH];
  int m_ncnt;
  int m_lfsr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      for (int i = 0; i < NCH; i++) begin m_cnt[i] = 0; m_wave[i] = 0; end
      m_ncnt = 0;
      m_lfsr = 1;
    end else begin
      if (m_phase == 15) begin
        for (int i = 0; i < NCH; i++) begin
          int p;
          p = (coarse_reg[i] % 16) * 256 + fine_reg[i];
          if (p == 0) p = 1;
          m_cnt[i] = m_cnt[i] + 1;
          if (m_cnt[i] >= p) begin m_cnt[i] = 0; m_wave[i] = 1 - m_wave[i]; end
        end
        begin
          int np;
          np = noise_reg % 32;
          if (np == 0) np = 1;
          m_ncnt = m_ncnt + 1;
          if (m_ncnt >= np) begin
            int fb;
            m_ncnt = 0;
            fb = (m_lfsr ^ (m_lfsr / 8)) % 2;
            m_lfsr = (m_lfsr / 2) + fb * 65536;
          end
        end
      end
      m_phase = (m_phase + 1) % 16;
    end
  end

  task automatic check_bit(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      for (int i = 0; i < NCH; i++)
        check_bit(cur_req, $sformatf("tone ch%0d", i), int'(tone_out[i]), m_wave[i]);
      check_bit(cur_req, "noise", int'(noise_out), m_lfsr % 2);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int toggles_b, toggles_c;
    logic prev_b, prev_c, saved_a;

    // R1: reset state; all periods 1 before release.
    for (int i = 0; i < NCH; i++) begin coarse_reg[i] = 8'h00; fine_reg[i] = 8'h01; end
    noise_reg = 8'h01;
    run(4);
    check_bit("R1", "tone at reset", int'(tone_out), 0);
    check_bit("R1", "noise at reset", int'(noise_out), 1);
    rst_n = 1'b1;

    // R2: outputs hold for 15 edges, change on the 16th.
    run(15);
    check_bit("R2", "tone after 15 edges", int'(tone_out), 0);
    check_bit("R2", "noise after 15 edges", int'(noise_out), 1);
    run(1);
    check_bit("R2", "tone after 16 edges", int'(tone_out), 7);
    check_bit("R2", "noise after 16 edges", int'(noise_out), 0);

    // R6: zero period equals one; compare B (0) against C (1); noise period 0.
    cmp_on = 1'b1;
    cur_req = "R6";
    fine_reg[0] = 8'h02; fine_reg[1] = 8'h00; fine_reg[2] = 8'h01;
    noise_reg = 8'h00;
    toggles_b = 0; toggles_c = 0;
    prev_b = tone_out[1]; prev_c = tone_out[2];
    for (int k = 0; k < 640; k++) begin
      run(1);
      if (tone_out[1] != prev_b) toggles_b++;
      if (tone_out[2] != prev_c) toggles_c++;
      prev_b = tone_out[1]; prev_c = tone_out[2];
    end
    check_bit("R6", "toggle count ch1 vs ch2", toggles_b, toggles_c);
    check_bit("R5", "toggles of period 1 in 640 clocks", toggles_c, 40);

    // R3 R4 R7: field assembly, upper coarse and noise bits set.
    cur_req = "R4";
    coarse_reg[0] = 8'hF0; fine_reg[0] = 8'h05;
    coarse_reg[1] = 8'hA1; fine_reg[1] = 8'h00;
    coarse_reg[2] = 8'h50; fine_reg[2] = 8'hFF;
    noise_reg = 8'hE3;
    run(9000);
    cur_req = "R3";
    coarse_reg[1] = 8'h00; fine_reg[1] = 8'h07;
    run(2000);
    cur_req = "R7";
    noise_reg = 8'h0B;
    run(3000);

    // R9: lower a period below the count reached; R10 others unaffected.
    cur_req = "R9";
    coarse_reg[0] = 8'h00; fine_reg[0] = 8'd200;
    coarse_reg[1] = 8'h00; fine_reg[1] = 8'h09;
    run(3200 * 2 + 800);
    saved_a = tone_out[0];
    fine_reg[0] = 8'd3;
    run(16);
    check_bit("R9", "ch0 toggled within one pulse", int'(tone_out[0] != saved_a), 1);
    cur_req = "R10";
    run(2000);

    // R8 R5: largest periods.
    cur_req = "R8";
    coarse_reg[2] = 8'h0F; fine_reg[2] = 8'hFF;
    noise_reg = 8'h1F;
    run(66000);
    cmp_on = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule